// File: doc/BRIEF.md
# Zero-Word Flag Stream Expander

This block rebuilds a stream of 16-bit configuration words from a compact bit-packed form held in a small storage memory. The packed form is read in as 16-bit words, but the block treats those words as one unbroken bit stream, taking the most significant bit of each word first. Every code in the stream starts with a single flag bit. A clear flag stands for a word of all zeros. A set flag is followed by 16 literal bits that are passed on unchanged as one word. A zero word therefore shrinks to one bit. A nonzero word grows by one bit, about 6 percent.

Codes are either 1 or 17 bits long and are packed with no gaps. A literal can therefore straddle two input words. A 32-bit holding buffer with a fill counter lines the bits up again. A job is started with a pulse that carries the number of words to produce. The block pulls packed words through a valid/ready input only when the buffer lacks a complete code, and it delivers words through a valid/ready output. When the last word has been taken, it raises a one-cycle done pulse and drops any padding bits left in the final input word.

Top module: `zword_expander`

## Requirements
- R1: After reset, `busy`, `done`, `in_ready` and `out_valid` are all low.
- R2: Bits are consumed most significant bit first within each input word, and codes continue across input word boundaries with no realignment.
- R3: A flag bit of 0 produces the output word 0x0000.
- R4: A flag bit of 1 produces, as one output word, the 16 bits that follow it, unchanged, including when those bits span two input words.
- R5: `in_ready` is low while the buffer already holds a complete next code, so a job accepts exactly ceil(packed bits / 16) input words and no more.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value.
- R7: Decoding stops after `word_count` output words. Bits left over in the final input word are discarded, and the next job starts at the most significant bit of its first input word.
- R8: `done` is high for exactly one cycle, the cycle after the last output word is accepted, and `busy` is low in that cycle.
- R9: A `start` with `word_count` equal to 0 gives a `done` pulse in the next cycle, with no input accepted and no output produced.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: The output register is reloaded in the same cycle its word is accepted. While complete codes are buffered and `out_ready` is held high, one word leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job; taken only while idle |
| word_count | input | 16 | Number of output words for the job |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse after the last word is taken |
| in_valid | input | 1 | Packed input word is valid |
| in_ready | output | 1 | Block accepts a packed word this cycle |
| in_data | input | 16 | Packed input word |
| out_valid | output | 1 | Expanded word is valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Expanded output word |

## Verification
Two events can land in the same cycle. One is the downstream acceptance of the current output word. The other is the decode of the next code into the output register. A run of zero flags packed into a single input word, with `out_ready` held high, forces the two together on every cycle; the bench then requires `out_valid` to stay high with no gap until the count is reached. The opposite case is provoked with ready patterns that stall the output. There the bench requires the held word to stay unchanged and no extra input fetch to occur, and it checks this against the number of input words computed from its own packing of the expected output.

// File: rtl/zfd_pkg.sv
`timescale 1ns/1ps
package zfd_pkg;
  localparam int unsigned ZFD_WORD_W = 16;
  localparam int unsigned ZFD_CNT_W  = 16;

  // length in bits of a code, given its leading flag
  function automatic int unsigned zfd_code_bits(input logic flag, input int unsigned word_w);
    return flag ? word_w + 1 : 1;
  endfunction
endpackage

// File: rtl/zfd_bitbuf.sv
`timescale 1ns/1ps
module zfd_bitbuf #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FILL_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      push,
  input  logic [WORD_W-1:0]         push_word,
  input  logic                      pop,
  input  logic [FILL_W-1:0]         pop_len,
  output logic [2*WORD_W-1:0]       bits,
  output logic [FILL_W-1:0]         fill
);
  localparam int unsigned BUF_W = 2 * WORD_W;

  logic [BUF_W-1:0]  bits_q;
  logic [FILL_W-1:0] fill_q;
  logic [BUF_W-1:0]  placed;

  // new word lands just below the bits already held
  assign placed = {push_word, {WORD_W{1'b0}}} >> fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      bits_q <= '0;
      fill_q <= '0;
    end else if (push) begin
      bits_q <= bits_q | placed;
      fill_q <= fill_q + FILL_W'(WORD_W);
    end else if (pop) begin
      bits_q <= bits_q << pop_len;
      fill_q <= fill_q - pop_len;
    end
  end

  assign bits = bits_q;
  assign fill = fill_q;
endmodule

// File: rtl/zfd_parser.sv
`timescale 1ns/1ps
module zfd_parser
  import zfd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FILL_W = 6
) (
  input  logic [WORD_W:0]     head,
  input  logic [FILL_W-1:0]   fill,
  output logic                flag,
  output logic [FILL_W-1:0]   code_len,
  output logic                avail,
  output logic [WORD_W-1:0]   word
);
  assign flag     = head[WORD_W];
  assign code_len = FILL_W'(zfd_code_bits(flag, WORD_W));
  assign avail    = (fill != '0) && (fill >= code_len);
  assign word     = flag ? head[WORD_W-1:0] : '0;
endmodule

// File: rtl/zfd_outreg.sv
`timescale 1ns/1ps
module zfd_outreg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              take,
  output logic              valid,
  output logic [WORD_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_word;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/zword_expander.sv
`timescale 1ns/1ps
module zword_expander
  import zfd_pkg::*;
#(
  parameter int unsigned WORD_W = ZFD_WORD_W,
  parameter int unsigned CNT_W  = ZFD_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_count,
  output logic              busy,
  output logic              done,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int unsigned BUF_W  = 2 * WORD_W;
  localparam int unsigned FILL_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0]  buf_bits;
  logic [FILL_W-1:0] fill;
  logic              dec_flag;
  logic [FILL_W-1:0] dec_len;
  logic              code_avail;
  logic [WORD_W-1:0] dec_word;

  logic [CNT_W-1:0]  left_dec, left_out;
  logic              busy_q, done_q;

  // named events
  logic start_ok, push, dec_fire, out_fire, last_take;

  assign start_ok  = start && !busy_q;
  assign dec_fire  = busy_q && (left_dec != '0) && code_avail && (!out_valid || out_ready);
  assign out_fire  = out_valid && out_ready;
  assign last_take = out_fire && (left_out == CNT_W'(1));
  assign in_ready  = busy_q && (left_dec != '0) && !code_avail;
  assign push      = in_valid && in_ready;

  zfd_bitbuf #(.WORD_W(WORD_W), .FILL_W(FILL_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(start_ok),
    .push(push), .push_word(in_data),
    .pop(dec_fire), .pop_len(dec_len),
    .bits(buf_bits), .fill(fill)
  );

  zfd_parser #(.WORD_W(WORD_W), .FILL_W(FILL_W)) u_parse (
    .head(buf_bits[BUF_W-1 -: WORD_W+1]), .fill(fill),
    .flag(dec_flag), .code_len(dec_len), .avail(code_avail), .word(dec_word)
  );

  zfd_outreg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(dec_fire), .load_word(dec_word),
    .take(out_ready), .valid(out_valid), .data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      left_dec <= '0;
      left_out <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q   <= (word_count != '0);
        done_q   <= (word_count == '0);
        left_dec <= word_count;
        left_out <= word_count;
      end else begin
        if (dec_fire) left_dec <= left_dec - CNT_W'(1);
        if (out_fire) left_out <= left_out - CNT_W'(1);
        if (last_take) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/zfd_chk.sv
`timescale 1ns/1ps
module zfd_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned FILL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              dec_fire,
  input logic              dec_flag,
  input logic              push,
  input logic [FILL_W-1:0] fill
);
  // R3
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire && !dec_flag |=> out_valid && (out_data == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(2 * WORD_W));

  // R5
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> fill == $past(fill) + FILL_W'(WORD_W));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !out_valid);

  // R7
  idle_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);
endmodule

bind zword_expander zfd_chk #(.WORD_W(WORD_W), .FILL_W(FILL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .dec_fire(dec_fire), .dec_flag(dec_flag), .push(push), .fill(fill)
);

// File: tb/zword_expander_tb.sv
`timescale 1ns/1ps
module zword_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] word_count = '0;
  logic          busy, done;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic [W-1:0] exp_words[$];
  logic [W-1:0] packed_q[$];
  logic [W-1:0] got_words[$];
  int           accepted_in;
  bit           stop_prod;

  always #(CLK_PERIOD/2) clk = ~clk;

  zword_expander u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .busy(busy), .done(done), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flag/literal packing, MSB first, padded to whole words
  task automatic pack_stream(input bit pad);
    bit b[$];
    foreach (exp_words[i]) begin
      if (exp_words[i] == '0) b.push_back(1'b0);
      else begin
        b.push_back(1'b1);
        for (int k = W-1; k >= 0; k--) b.push_back(exp_words[i][k]);
      end
    end
    while (b.size() % W != 0) b.push_back(pad);
    packed_q.delete();
    for (int i = 0; i < b.size(); i += W) begin
      logic [W-1:0] wv;
      for (int k = 0; k < W; k++) wv[W-1-k] = b[i+k];
      packed_q.push_back(wv);
    end
  endtask

  task automatic producer();
    int idx = 0;
    accepted_in = 0;
    while (!stop_prod) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = (idx < packed_q.size()) ? packed_q[idx] : 16'hFFFF;
      #1;
      if (in_ready) begin
        idx++;
        accepted_in++;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic consumer(input int n, input int mode, output int gaps);
    int cnt = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [W-1:0] held = '0;
    gaps = 0;
    got_words.delete();
    while (cnt < n) begin
      @(negedge clk);
      case (mode)
        1:       out_ready = (cyc % 2) == 1;
        2:       out_ready = (cyc % 4) == 3;
        default: out_ready = 1'b1;
      endcase
      cyc++;
      #1;
      if (stalled)
        check(out_valid && out_data == held, "R6", "held word", out_data, held);
      stalled = 0;
      if (cnt > 0 && !out_valid) gaps++;
      if (out_valid) begin
        if (out_ready) begin
          got_words.push_back(out_data);
          cnt++;
        end else begin
          stalled = 1;
          held = out_data;
        end
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    check(done === 1'b1 && busy === 1'b0, "R8", "done after last take", {done, busy}, 2'b10);
    @(negedge clk);
    #1;
    check(done === 1'b0, "R8", "done width", done, 0);
    check(in_ready === 1'b0, "R7", "no fetch after job", in_ready, 0);
  endtask

  task automatic run_job(input string req, input int mode, input bit restart, output int gaps);
    int n = exp_words.size();
    stop_prod = 0;
    fork
      producer();
      begin
        @(negedge clk);
        start = 1'b1;
        word_count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
          repeat (3) @(negedge clk);
          start = 1'b1;   // R10: must be ignored
          word_count = CW'(1);
          @(negedge clk);
          start = 1'b0;
        end
      end
      begin
        consumer(n, mode, gaps);
        stop_prod = 1;
      end
    join
    check(got_words.size() == n, req, "word count", got_words.size(), n);
    foreach (exp_words[i])
      if (i < got_words.size())
        check(got_words[i] === exp_words[i], req, $sformatf("word %0d", i), got_words[i], exp_words[i]);
    check(accepted_in == packed_q.size(), "R5", "input words taken", accepted_in, packed_q.size());
  endtask

  task automatic t_reset();
    check(!busy && !done && !in_ready && !out_valid, "R1", "idle after reset",
          {busy, done, in_ready, out_valid}, 0);
  endtask

  task automatic t_zero_run();
    int gaps;
    exp_words.delete();
    for (int i = 0; i < 16; i++) exp_words.push_back('0);
    pack_stream(1'b1);
    run_job("R3", 0, 0, gaps);
    check(gaps == 0, "R11", "one word per cycle", gaps, 0);
    exp_words.delete();
    for (int i = 0; i < 40; i++) exp_words.push_back('0);
    pack_stream(1'b1);
    run_job("R7", 0, 0, gaps);
  endtask

  task automatic t_literals();
    int gaps;
    exp_words = '{16'h8001, 16'hFFFF, 16'h1234, 16'hA5A5, 16'h0F0F};
    pack_stream(1'b0);
    run_job("R4", 0, 0, gaps);
  endtask

  task automatic t_msb_order();
    int gaps;
    exp_words = '{16'h0000, 16'h7FFF};
    packed_q  = '{16'h5FFF, 16'hC000};
    run_job("R2", 0, 0, gaps);
  endtask

  task automatic t_mixed(input int mode);
    int gaps;
    exp_words.delete();
    for (int i = 0; i < 20; i++)
      exp_words.push_back((i % 3 == 0) ? 16'h0000 : W'(i * 16'h2B5 + 16'h11));
    pack_stream(1'b1);
    run_job("R6", mode, 0, gaps);
  endtask

  task automatic t_padding_flush();
    int gaps;
    exp_words = '{16'h0000};
    pack_stream(1'b1);
    check(packed_q[0] == 16'h7FFF, "R7", "padded word", packed_q[0], 16'h7FFF);
    run_job("R7", 0, 0, gaps);
    exp_words = '{16'h1234};
    pack_stream(1'b0);
    run_job("R7", 0, 0, gaps);
  endtask

  task automatic t_zero_count();
    @(negedge clk);
    start = 1'b1;
    word_count = '0;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(done === 1'b1 && !busy && !out_valid && !in_ready, "R9", "empty job",
          {done, busy, out_valid, in_ready}, 4'b1000);
    @(negedge clk);
    #1;
    check(done === 1'b0, "R9", "done width", done, 0);
  endtask

  task automatic t_start_busy();
    int gaps;
    exp_words = '{16'h00F0, 16'h0000, 16'hBEEF, 16'h0001, 16'h0000, 16'h8000};
    pack_stream(1'b1);
    run_job("R10", 1, 1, gaps);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    t_reset();
    t_zero_run();
    t_literals();
    t_msb_order();
    t_mixed(1);
    t_mixed(2);
    t_padding_flush();
    t_zero_count();
    t_start_busy();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule